// File: doc/BRIEF.md
# Command-Register MDIO Management Master

This block lets software run single management transactions against an external PHY over the two-wire MDC/MDIO bus. Software programs one 32-bit command word through a byte-enabled write port. The word holds an operation code, a 5-bit PHY address, a 5-bit register address and a 16-bit data field. Only a write that includes the top byte starts a transaction, so software can stage the lower fields with narrow writes and then commit the command.

While a transaction runs, the block divides the system clock down to MDC and shifts out a clause-22 frame. That frame is a preamble of ones, the start pattern, the operation, both addresses, a turnaround and then the data. On a read it releases MDIO for the turnaround and data phases and shifts the PHY's answer into the data field. At the end it sets a ready flag. If the interrupt-enable bit is set, it holds an interrupt request until software clears the flag by issuing the next command.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command word reads 0x00000000, `irq_o` is 0, `mdc_o` is 0 and `mdio_oe_o` is 0.
- R2: A write updates only the bytes whose enable bit is set (`wr_be_i[k]` covers bits 8k+7:8k), and bits 31:30 always read as 0.
- R3: A write whose byte enables exclude byte 3 starts no transaction and MDC does not toggle.
- R4: For opcode 01 (bits 27:26), the block shifts out 64 bits MSB first with MDIO driven throughout. The bits are 32 ones, then 01, the opcode, the PHY address (bits 25:21), the register address (bits 20:16), turnaround 10 and the data (bits 15:0).
- R5: For opcode 10, MDIO is driven for the first 46 bits and released for the turnaround and the 16 data bits. The 16 bits are sampled on rising MDC, MSB first, and placed in bits 15:0.
- R6: Ready (bit 28) takes the written value on a byte-3 write and is set to 1 when a transaction ends.
- R7: `irq_o` is 1 exactly when ready (bit 28) and interrupt enable (bit 29) are both 1, and it stays high until a byte-3 write clears ready.
- R8: A byte-3 write carrying opcode 00 or 11 produces no MDC activity and sets ready at the same clock edge that accepts the write.
- R9: Any write accepted while a transaction is in progress has no effect on the command word. This includes a write at the edge where the transaction completes.
- R10: MDC has a period of 2·MDC_HALF_DIV system clocks. MDIO changes only on a falling MDC edge. Ready is set exactly 128·MDC_HALF_DIV clock edges after the launching edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Command-word write strobe |
| wr_be_i | input | 4 | Byte enables for the write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current command word |
| irq_o | output | 1 | Transaction-done interrupt request |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
Completion of a transaction and a software write to the command word can fall on the same clock edge. Completion sets ready and loads the read data. The write would replace the fields and clear ready. The bench launches a command and counts exactly 128·MDC_HALF_DIV edges. It checks that ready is still 0 one edge before completion, then presents a full-word write timed to land on the completion edge. Afterwards it expects ready set and every field still holding the original command, so the colliding write must have been dropped and the completion kept.

// File: rtl/mdio_cmd_pkg.sv
`timescale 1ns/1ps
package mdio_cmd_pkg;

  localparam int PHY_AW     = 5;
  localparam int REG_AW     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam logic [IDX_W-1:0] TA_POS   = IDX_W'(FRAME_BITS - DATA_W - 2);
  localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(FRAME_BITS - DATA_W);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FRAME_BITS - 1);

  typedef enum logic [1:0] {
    OP_RSV0  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSV3  = 2'b11
  } mdio_op_e;

  typedef struct packed {
    logic [1:0]        rsvd;
    logic              irq_en;
    logic              ready;
    mdio_op_e          op;
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
    logic [DATA_W-1:0] data;
  } cmd_word_t;

endpackage

// File: rtl/mdio_clk_gen.sv
`timescale 1ns/1ps
module mdio_clk_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_stb_o,
  output logic fall_stb_o
);

  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick = run_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o      = mdc_q;
  assign rise_stb_o = tick && !mdc_q;
  assign fall_stb_o = tick && mdc_q;

  // MDC parks low whenever no frame is running
  p_mdc_idle_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !mdc_q);

  p_mdc_rise_needs_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_q) |-> $past(run_i));

endmodule

// File: rtl/mdio_frame_shifter.sv
`timescale 1ns/1ps
module mdio_frame_shifter
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mdio_op_e          op_i,
  input  logic [PHY_AW-1:0] phy_i,
  input  logic [REG_AW-1:0] reg_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rise_stb_i,
  input  logic              fall_stb_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_rd_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);

  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      idx_nxt;
  logic [DATA_W-1:0]     rd_sh_q;
  logic                  busy_q;
  logic                  is_rd_q;
  logic                  oe_q;
  logic                  last_bit;

  assign idx_nxt  = idx_q + 1'b1;
  assign last_bit = (idx_q == LAST_POS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      idx_q   <= '0;
      rd_sh_q <= '0;
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      frame_q <= {{PRE_BITS{1'b1}}, 2'b01, op_i, phy_i, reg_i,
                  (op_i == OP_READ) ? 2'b11 : 2'b10, data_i};
      idx_q   <= '0;
      busy_q  <= 1'b1;
      is_rd_q <= (op_i == OP_READ);
      oe_q    <= 1'b1;
    end else if (busy_q) begin
      if (rise_stb_i && is_rd_q && (idx_q >= DATA_POS))
        rd_sh_q <= {rd_sh_q[DATA_W-2:0], mdio_i};
      if (fall_stb_i) begin
        if (last_bit) begin
          busy_q  <= 1'b0;
          oe_q    <= 1'b0;
          frame_q <= '0;
        end else begin
          frame_q <= frame_q << 1;
          idx_q   <= idx_nxt;
          oe_q    <= !(is_rd_q && (idx_nxt >= TA_POS));
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_stb_i && last_bit;
  assign done_rd_o = is_rd_q;
  assign rd_data_o = rd_sh_q;
  assign mdio_o    = frame_q[FRAME_BITS-1];
  assign mdio_oe_o = oe_q;

  p_mdio_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !fall_stb_i |=> $stable(mdio_o));

  p_read_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && is_rd_q && (idx_q >= TA_POS) |-> !mdio_oe_o);

  p_write_driven_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !is_rd_q |-> mdio_oe_o);

endmodule

// File: rtl/mdio_cmd_reg.sv
`timescale 1ns/1ps
module mdio_cmd_reg
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_be_i,
  input  logic [31:0]       wr_data_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              done_rd_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output cmd_word_t         cmd_o,
  output logic              start_o,
  output cmd_word_t         launch_cmd_o,
  output logic              irq_o
);

  cmd_word_t cmd_q;
  cmd_word_t merged;
  logic      accept;
  logic      launch;
  logic      op_valid;

  assign accept = wr_en_i && !busy_i;
  assign launch = accept && wr_be_i[3];

  always_comb begin
    merged = cmd_q;
    for (int b = 0; b < 4; b++) begin
      if (wr_be_i[b]) merged[8*b +: 8] = wr_data_i[8*b +: 8];
    end
    merged.rsvd = 2'b00;
    op_valid = (merged.op == OP_WRITE) || (merged.op == OP_READ);
    // reserved opcode completes at once
    if (wr_be_i[3] && !op_valid) merged.ready = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (done_i) begin
      cmd_q.ready <= 1'b1;
      if (done_rd_i) cmd_q.data <= rd_data_i;
    end else if (accept) begin
      cmd_q <= merged;
    end
  end

  assign cmd_o        = cmd_q;
  assign launch_cmd_o = merged;
  assign start_o      = launch && op_valid;
  assign irq_o        = cmd_q.ready && cmd_q.irq_en;

  p_ready_on_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> cmd_q.ready);

  p_no_launch_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !start_o);

  p_frozen_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !done_i |=> $stable(cmd_q));

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(wr_en_i && wr_be_i[3]) |=> irq_o);

endmodule

// File: rtl/mdio_cmd_master.sv
`timescale 1ns/1ps
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int unsigned MDC_HALF_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_be_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);

  cmd_word_t         cmd_w;
  cmd_word_t         launch_w;
  logic              start_w;
  logic              busy_w;
  logic              done_w;
  logic              done_rd_w;
  logic [DATA_W-1:0] rd_sh_w;
  logic              rise_w;
  logic              fall_w;

  mdio_cmd_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_be_i     (wr_be_i),
    .wr_data_i   (wr_data_i),
    .busy_i      (busy_w),
    .done_i      (done_w),
    .done_rd_i   (done_rd_w),
    .rd_data_i   (rd_sh_w),
    .cmd_o       (cmd_w),
    .start_o     (start_w),
    .launch_cmd_o(launch_w),
    .irq_o       (irq_o)
  );

  mdio_clk_gen #(.HALF_DIV(MDC_HALF_DIV)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_w),
    .mdc_o     (mdc_o),
    .rise_stb_o(rise_w),
    .fall_stb_o(fall_w)
  );

  mdio_frame_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .op_i      (launch_w.op),
    .phy_i     (launch_w.phy),
    .reg_i     (launch_w.regad),
    .data_i    (launch_w.data),
    .rise_stb_i(rise_w),
    .fall_stb_i(fall_w),
    .mdio_i    (mdio_i),
    .busy_o    (busy_w),
    .done_o    (done_w),
    .done_rd_o (done_rd_w),
    .rd_data_o (rd_sh_w),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  assign rd_data_o = cmd_w;

endmodule

// File: tb/mdio_cmd_master_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb_top;

  localparam int HALF_DIV = 4;
  localparam int DONE_EDGES = 128 * HALF_DIV;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o, mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  always #4 clk_i = ~clk_i;

  mdio_cmd_master #(.MDC_HALF_DIV(HALF_DIV)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_be_i(wr_be_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .mdc_o(mdc_o),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done_flag = 1'b0;

  // PHY model
  int          rise_cnt = 0;
  logic [63:0] cap_bits = '0;
  logic [63:0] cap_oe   = '0;
  logic [15:0] phy_rdval = '0;
  realtime     t_r0 = 0, t_r1 = 0;

  always @(posedge mdc_o) begin
    cap_bits = {cap_bits[62:0], mdio_o};
    cap_oe   = {cap_oe[62:0], mdio_oe_o};
    if (rise_cnt == 0) t_r0 = $realtime;
    if (rise_cnt == 1) t_r1 = $realtime;
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc_o) begin
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_rdval[63-rise_cnt];
    else mdio_i = 1'b1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_cap();
    rise_cnt = 0;
    cap_bits = '0;
    cap_oe   = '0;
  endtask

  task automatic bus_write(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_be_i = be; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = '0; wr_data_i = '0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 4000; i++) begin
      if (rd_data_o[28]) break;
      @(negedge clk_i);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    return {32'hFFFF_FFFF, 2'b01, w[27:26], w[25:21], w[20:16], 2'b10, w[15:0]};
  endfunction

  typedef struct packed {
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [15:0] rdval;
    logic [31:0] exp_reg;
    logic        exp_irq;
    logic        launch;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h047F_A5C3, 4'hF, 16'h0000, 32'h147F_A5C3, 1'b0, 1'b1}, // R4 write
    '{32'h0A22_0000, 4'hF, 16'h1234, 32'h1A22_1234, 1'b0, 1'b1}, // R5 read
    '{32'h0000_BEEF, 4'h3, 16'h0000, 32'h1A22_BEEF, 1'b0, 1'b0}, // R2 R3 low half
    '{32'h0015_0000, 4'h4, 16'h0000, 32'h1A15_BEEF, 1'b0, 1'b0}, // R2 single byte
    '{32'h0800_0000, 4'h8, 16'hC0DE, 32'h1815_C0DE, 1'b0, 1'b1}, // R5 byte-3 launch
    '{32'hEC00_0000, 4'h8, 16'h0000, 32'h3C15_C0DE, 1'b1, 1'b0}, // R8 R2 reserved op
    '{32'h2420_0001, 4'hF, 16'h0000, 32'h3420_0001, 1'b1, 1'b1}, // R7 irq write
    '{32'h0000_0000, 4'hF, 16'h0000, 32'h1000_0000, 1'b0, 1'b0}  // R8 op 00
  };

  initial begin
    #(8ns * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    if (!done_flag) $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 reg", 64'(rd_data_o), 64'h0);
    check("R1 irq", 64'(irq_o), 64'h0);
    check("R1 mdc", 64'(mdc_o), 64'h0);
    check("R1 oe", 64'(mdio_oe_o), 64'h0);

    for (int v = 0; v < NV; v++) begin
      clear_cap();
      phy_rdval = VEC[v].rdval;
      bus_write(VEC[v].be, VEC[v].wdata);
      if (VEC[v].launch) begin
        check("R7 irq low in flight", 64'(irq_o), 64'h0);
        wait_ready();
        @(negedge clk_i);
        check("R4 R5 rise count", 64'(rise_cnt), 64'd64);
        if (VEC[v].exp_reg[27:26] == 2'b10) begin
          check("R5 oe pattern", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
          check("R5 header bits", cap_bits & 64'hFFFF_FFFF_FFFC_0000,
                exp_frame(VEC[v].exp_reg) & 64'hFFFF_FFFF_FFFC_0000);
        end else begin
          check("R4 oe pattern", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
          check("R4 frame bits", cap_bits, exp_frame(VEC[v].exp_reg));
        end
      end else begin
        repeat (20) @(negedge clk_i);
        check("R3 R8 no mdc", 64'(rise_cnt), 64'd0);
      end
      check("R2 R6 reg", 64'(rd_data_o), 64'(VEC[v].exp_reg));
      check("R7 irq", 64'(irq_o), 64'(VEC[v].exp_irq));
    end

    // R8: ready already set right after the accepting edge
    bus_write(4'h8, 32'h0C00_0000);
    check("R8 immediate ready", 64'(rd_data_o[28]), 64'h1);

    // R10 R9: exact completion edge, colliding write dropped
    clear_cap();
    bus_write(4'hF, 32'h04A5_5A5A);
    repeat (DONE_EDGES - 1) @(negedge clk_i);
    check("R10 not ready one edge early", 64'(rd_data_o[28]), 64'h0);
    wr_en_i = 1'b1; wr_be_i = 4'hF; wr_data_i = 32'h0800_0000;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = '0; wr_data_i = '0;
    check("R9 R10 collision", 64'(rd_data_o), 64'h14A5_5A5A);
    check("R10 mdc period", 64'(longint'(t_r1 - t_r0)), 64'(2 * HALF_DIV * 8));

    // R9: lower-byte write mid-transaction ignored
    clear_cap();
    bus_write(4'hF, 32'h04A5_1111);
    repeat (100) @(negedge clk_i);
    bus_write(4'h1, 32'h0000_00FF);
    wait_ready();
    @(negedge clk_i);
    check("R9 mid write ignored", 64'(rd_data_o), 64'h14A5_1111);
    check("R4 frame after ignore", cap_bits, exp_frame(32'h04A5_1111));

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule